// File: doc/BRIEF.md
# DMA Operand Packing Unit

This unit sits in the data path of a dual-address DMA channel, between the source read and the destination write. When the source and destination ports have the same width, it passes data straight through. When the widths differ, it packs pairs of bytes into words, or splits each word into two bytes. Only 8-bit and 16-bit ports are handled. Port sizes come from the channel control fields and must stay constant while the channel is active. Between transfers they are changed only after a `clear`.

Same-width transfers never use the holding register. A channel stopped after any number of byte-to-byte (or word-to-word) transfers therefore holds no leftover data. A stop that arrives in the middle of a byte-to-word pack leaves one byte held. The unit then raises a residual flag and keeps that byte until the channel is cleared.

Top module: `dma_pack_unit`

## Requirements
- R1: After reset `wr_valid` and `residual` are 0 and `rd_ready` is 1.
- R2: With both sizes byte (size encoding 0 = byte, 1 = word), each accepted read (`rd_valid` and `rd_ready` high at a clock edge) produces exactly one write in the next cycle. That write carries `wr_data = {8'h00, rd_data[7:0]}` and `wr_size = 0`.
- R3: With both sizes word, each accepted read produces one write in the next cycle, with `wr_data = rd_data` and `wr_size = 1`.
- R4: With byte source and word destination, no write follows the first byte of a pair. In the cycle after the second byte, one write appears with `wr_data = {first, second}` (first byte in bits 15:8) and `wr_size = 1`.
- R5: With word source and byte destination, an accepted word produces two byte writes in the next two cycles: `{8'h00, rd_data[15:8]}` first, then `{8'h00, rd_data[7:0]}`. `rd_ready` is 0 between them.
- R6: A read accepted at the same edge as `stop` is still processed. From the next cycle on, `rd_ready` is 0, reads are ignored and no new write is produced until `clear`.
- R7: If a stop leaves one packed byte held, `residual` is 1 from the cycle after the stop and stays 1 until `clear`.
- R8: A stop in byte-to-byte or word-to-word mode never raises `residual`, whatever number of transfers preceded it.
- R9: `clear` drops the held byte, the pending byte, the stopped state and `residual`. In the next cycle `rd_ready` is 1 and `residual` is 0.
- R10: A stop that arrives while the low byte of an unpacked word is still pending does not cancel that byte: it is still written in the cycle it is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Channel clear: drops held data, stop state and residual flag |
| src_size | input | 1 | Source port size, 0 = byte, 1 = word |
| dst_size | input | 1 | Destination port size, 0 = byte, 1 = word |
| rd_valid | input | 1 | Source read data valid |
| rd_data | input | 16 | Source read data; a byte source uses bits 7:0 |
| rd_ready | output | 1 | Unit can take a read this cycle |
| stop | input | 1 | Channel stop request |
| wr_valid | output | 1 | Destination write strobe |
| wr_data | output | 16 | Destination write data; a byte write uses bits 7:0 |
| wr_size | output | 1 | Size of the current write, 0 = byte, 1 = word |
| residual | output | 1 | A packed byte was left held by a stop |

## Verification
The hardest situation to reach is a stop that lands exactly in the cycle between the two byte writes of an unpacked word. The read must already have been accepted, and the stop must meet the pending low byte at the same edge. The bench reaches it with a directed sequence: it issues one word read and drives `stop` on the very next cycle. It then checks that the low byte still comes out and that nothing follows. A second hard case is a stop landing while a packed byte is held, with and without a read at the same edge. Random scenarios with random sizes, gaps, lengths and stop points cover both cases, alongside directed cases for each of them.

// File: rtl/dmapk_pkg.sv
package dmapk_pkg;

  typedef enum logic {
    PSZ_BYTE = 1'b0,
    PSZ_WORD = 1'b1
  } port_sz_e;

  typedef enum logic [1:0] {
    XF_DIRECT = 2'd0,
    XF_PACK   = 2'd1,
    XF_SPLIT  = 2'd2
  } xfer_mode_e;

  function automatic xfer_mode_e mode_of(input port_sz_e src, input port_sz_e dst);
    if (src == dst)           return XF_DIRECT;
    else if (src == PSZ_BYTE) return XF_PACK;
    else                      return XF_SPLIT;
  endfunction

endpackage

// File: rtl/dmapk_ctrl.sv
module dmapk_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic stop,
  input  logic rd_valid,
  input  logic pending,
  output logic rd_ready,
  output logic accept,
  output logic stopped
);

  logic stopped_q;

  always_ff @(posedge clk) begin
    if (rst || clear) stopped_q <= 1'b0;
    else if (stop)    stopped_q <= 1'b1;
  end

  assign stopped  = stopped_q;
  assign rd_ready = !stopped_q && !pending;
  assign accept   = rd_valid && rd_ready;

  p_ready_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (stop && !clear) |=> !rd_ready);

endmodule

// File: rtl/dmapk_hold.sv
module dmapk_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              held,
  output logic              held_next,
  output logic              pair_done,
  output logic [BYTE_W-1:0] hold_byte
);

  logic              held_q;
  logic [BYTE_W-1:0] byte_q;

  assign held_next = (rst || clear) ? 1'b0 : (load ? !held_q : held_q);
  assign pair_done = load && held_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held_q <= 1'b0;
      byte_q <= '0;
    end else if (load) begin
      held_q <= !held_q;
      if (!held_q) byte_q <= din;
    end
  end

  assign held      = held_q;
  assign hold_byte = byte_q;

  p_pair_frees_r4: assert property (@(posedge clk) disable iff (rst)
    (pair_done && !clear) |=> !held);

endmodule

// File: rtl/dmapk_split.sv
module dmapk_split #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                load,
  input  logic [2*BYTE_W-1:0] din,
  output logic                pending,
  output logic [BYTE_W-1:0]   lo_byte
);

  logic              pend_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      lo_q   <= din[BYTE_W-1:0];
    end else begin
      pend_q <= 1'b0;
    end
  end

  assign pending = pend_q;
  assign lo_byte = lo_q;

  p_pending_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    pending |=> !pending);

endmodule

// File: rtl/dma_pack_unit.sv
module dma_pack_unit #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                src_size,
  input  logic                dst_size,
  input  logic                rd_valid,
  input  logic [2*BYTE_W-1:0] rd_data,
  output logic                rd_ready,
  input  logic                stop,
  output logic                wr_valid,
  output logic [2*BYTE_W-1:0] wr_data,
  output logic                wr_size,
  output logic                residual
);
  import dmapk_pkg::*;

  localparam int DATA_W = 2 * BYTE_W;

  xfer_mode_e        mode;
  logic              accept, stopped, pending;
  logic              held, held_next, pair_done;
  logic [BYTE_W-1:0] hold_byte, lo_byte;

  assign mode = mode_of(port_sz_e'(src_size), port_sz_e'(dst_size));

  dmapk_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .stop     (stop),
    .rd_valid (rd_valid),
    .pending  (pending),
    .rd_ready (rd_ready),
    .accept   (accept),
    .stopped  (stopped)
  );

  dmapk_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .load      (accept && (mode == XF_PACK)),
    .din       (rd_data[BYTE_W-1:0]),
    .held      (held),
    .held_next (held_next),
    .pair_done (pair_done),
    .hold_byte (hold_byte)
  );

  dmapk_split #(.BYTE_W(BYTE_W)) u_split (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .load    (accept && (mode == XF_SPLIT)),
    .din     (rd_data),
    .pending (pending),
    .lo_byte (lo_byte)
  );

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_size  <= PSZ_BYTE;
    end else begin
      wr_valid <= 1'b0;
      if (pending) begin
        wr_valid <= 1'b1;
        wr_data  <= {{BYTE_W{1'b0}}, lo_byte};
        wr_size  <= PSZ_BYTE;
      end else if (accept) begin
        unique case (mode)
          XF_DIRECT: begin
            wr_valid <= 1'b1;
            wr_size  <= dst_size;
            wr_data  <= (dst_size == PSZ_WORD) ? rd_data
                                               : {{BYTE_W{1'b0}}, rd_data[BYTE_W-1:0]};
          end
          XF_PACK: begin
            if (pair_done) begin
              wr_valid <= 1'b1;
              wr_size  <= PSZ_WORD;
              wr_data  <= {hold_byte, rd_data[BYTE_W-1:0]};
            end
          end
          XF_SPLIT: begin
            wr_valid <= 1'b1;
            wr_size  <= PSZ_BYTE;
            wr_data  <= {{BYTE_W{1'b0}}, rd_data[DATA_W-1:BYTE_W]};
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear)         residual <= 1'b0;
    else if (stop || stopped) residual <= held_next;
  end

  p_resid_has_byte_r7: assert property (@(posedge clk) disable iff (rst)
    residual |-> held);

  p_resid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (residual && !clear) |=> residual);

  p_split_two_writes_r5: assert property (@(posedge clk) disable iff (rst || clear)
    (accept && mode == XF_SPLIT) |=> wr_valid);

  p_quiet_when_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    (stopped && !pending) |=> !wr_valid);

  p_direct_no_resid_r8: assert property (@(posedge clk) disable iff (rst || clear)
    (stopped && mode == XF_DIRECT && !held) |-> !residual);

endmodule

// File: tb/dma_pack_unit_test.sv
module dma_pack_unit_test;

  localparam time CYC = 5ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic        src_size = 1'b0;
  logic        dst_size = 1'b0;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic        stop = 1'b0;
  logic        rd_ready, wr_valid, wr_size, residual;
  logic [15:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [16:0] exp_q[$];
  bit          m_held = 1'b0;
  logic [7:0]  m_byte = '0;
  bit          m_stopped = 1'b0;

  always #(CYC/2) clk = ~clk;

  dma_pack_unit uut (
    .clk(clk), .rst(rst), .clear(clear), .src_size(src_size), .dst_size(dst_size),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .stop(stop),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_size(wr_size), .residual(residual)
  );

  function automatic string tag_of(input logic s, input logic d);
    if (s == d) return s ? "R3" : "R2";
    return s ? "R5" : "R4";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Write monitor: every write must match the head of the expected queue.
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6 unexpected write: actual=%0h expected=none", {wr_size, wr_data});
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if ({wr_size, wr_data} !== e) begin
          n_bad++;
          $display("FAIL %s write: actual=%0h expected=%0h",
                   tag_of(src_size, dst_size), {wr_size, wr_data}, e);
        end
      end
    end
  end

  task automatic model_read(input logic [15:0] d);
    if (src_size == dst_size)
      exp_q.push_back(dst_size ? {1'b1, d} : {1'b0, 8'h00, d[7:0]});
    else if (!src_size) begin
      if (m_held) begin
        exp_q.push_back({1'b1, m_byte, d[7:0]});
        m_held = 1'b0;
      end else begin
        m_byte = d[7:0];
        m_held = 1'b1;
      end
    end else begin
      exp_q.push_back({1'b0, 8'h00, d[15:8]});
      exp_q.push_back({1'b0, 8'h00, d[7:0]});
    end
  endtask

  task automatic rd_one(input logic [15:0] d);
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1'b1;
    rd_data  = d;
    model_read(d);
    @(posedge clk);
    #1 rd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear(input logic s, input logic d);
    @(negedge clk);
    clear = 1'b1;
    @(posedge clk);
    #1 clear = 1'b0;
    m_held = 1'b0;
    m_stopped = 1'b0;
    @(negedge clk);
    check("R9", "residual after clear", residual, 0);
    check("R9", "rd_ready after clear", rd_ready, 1);
    src_size = s;
    dst_size = d;
  endtask

  task automatic do_stop(input string req);
    @(negedge clk);
    stop = 1'b1;
    @(posedge clk);
    #1 stop = 1'b0;
    m_stopped = 1'b1;
    @(negedge clk);
    check(req, "residual after stop", residual, m_held ? 1 : 0);
    check("R6", "rd_ready after stop", rd_ready, 0);
    // reads offered while stopped must be ignored
    rd_valid = 1'b1;
    rd_data  = 16'hBEEF;
    idle(3);
    rd_valid = 1'b0;
    idle(2);
    check("R6", "no writes while stopped", exp_q.size(), 0);
    check("R7", "residual sticky", residual, m_held ? 1 : 0);
  endtask

  task automatic drain(input string req);
    idle(4);
    check(req, "pending writes", exp_q.size(), 0);
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", "wr_valid at reset", wr_valid, 0);
    check("R1", "residual at reset", residual, 0);
    check("R1", "rd_ready at reset", rd_ready, 1);

    // R2: byte to byte, then stop after an odd count (R8)
    do_clear(1'b0, 1'b0);
    rd_one(16'h1234); rd_one(16'h0056); rd_one(16'hFF78);
    drain("R2");
    do_stop("R8");

    // R3: word to word
    do_clear(1'b1, 1'b1);
    rd_one(16'hA1B2); rd_one(16'hC3D4);
    drain("R3");
    do_stop("R8");

    // R4: byte to word packing, upper lane first
    do_clear(1'b0, 1'b1);
    rd_one(16'h00AB); rd_one(16'h00CD); rd_one(16'h0011); rd_one(16'h0022);
    drain("R4");

    // R7: stop with one packed byte held
    rd_one(16'h0077);
    idle(2);
    check("R4", "no write after single byte", exp_q.size(), 0);
    do_stop("R7");

    // R5: word to byte, rd_ready low between halves
    do_clear(1'b1, 1'b0);
    rd_one(16'h1234);
    @(negedge clk);
    check("R5", "rd_ready between halves", rd_ready, 0);
    rd_one(16'h5678);
    drain("R5");

    // R10: stop arrives while low byte pending
    rd_one(16'h9ABC);
    do_stop("R10");

    // R6: read accepted at the stop edge is still processed
    do_clear(1'b0, 1'b1);
    rd_one(16'h0033);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = 16'h0044; stop = 1'b1;
    model_read(16'h0044);
    @(posedge clk);
    #1 begin rd_valid = 1'b0; stop = 1'b0; end
    m_stopped = 1'b1;
    drain("R6");
    check("R7", "no residual after completed pair", residual, 0);

    // random scenarios
    for (int sc = 0; sc < 60; sc++) begin
      logic s, d;
      int n;
      s = 1'($urandom % 2);
      d = 1'($urandom % 2);
      do_clear(s, d);
      n = 1 + ($urandom % 9);
      for (int k = 0; k < n; k++) begin
        rd_one(16'($urandom));
        if ($urandom % 3 == 0) idle(1 + ($urandom % 3));
      end
      if ($urandom % 2) begin
        do_stop((s == d) ? "R8" : "R7");
      end else begin
        drain(tag_of(s, d));
      end
    end

    do_clear(1'b0, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule